// File: doc/BRIEF.md
# Clock-Generator Configuration Register Bank with SMBus Block-Write Slave

This block is a two-wire serial bus slave that keeps the 21 eight-bit configuration registers of a programmable clock generator. It never drives the clock line. It drives the data line only through an open-drain enable. The host changes the registers with block-write transactions only. After the address, the first two bytes are a command code and a byte count. Both are acknowledged and both are thrown away. The data bytes that follow fill the registers in ascending order starting at register 0, and loading ends only when the host signals a stop. The count byte sets no limit.

Two register pairs, (11,12) and (13,14), feed dividers and spread settings that must never see a half-updated value. Bytes for these registers are held in shadow storage. A pair reaches its outputs only when the same transaction delivered both of its bytes. A read transaction returns the registers from register 0 upward, and register 8 sets how many of them are returned. The bus lines are sampled on the system clock, which must run many times faster than the standard-mode bus rate of 100 kbit/s or less.

Top module: `smb_cfg_bank`

## Requirements
- R1: After reset, every register reads 0x00 except register 8, which reads 0x08, and register 9, which reads 0x10. `sda_oe` is 0. Register i appears on `cfg_o[8*i+7:8*i]`.
- R2: The slave pulls SDA low in the acknowledge slot only when the 7 address bits (sent MSB first, followed by the R/W bit, 0 = write, 1 = read) equal `DEV_ADDR`. On a mismatch it acknowledges nothing and changes no register.
- R3: In a write, the first two bytes after the address are acknowledged and discarded, whatever their values. The first byte after them lands in register 0.
- R4: Data byte k of a write (k counted from 0 after the two discarded bytes) goes to register k. Every data byte is acknowledged. Bytes beyond register 20 are ignored. The count byte does not limit loading, and a stop after any byte keeps the registers already written.
- R5: Registers 11 and 12 form one pair, and registers 13 and 14 form another. A pair changes only when the transaction delivered both of its bytes. The update appears when the transaction ends with a stop or a repeated start. Otherwise neither register of the pair changes.
- R6: A write of 0x00 to register 8 is ignored, so register 8 keeps its previous value.
- R7: A read sends bytes MSB first, starting at register 0. Byte k is register k when k is less than the value of register 8 and less than 21. Otherwise the slave leaves SDA released, so the byte reads 0xFF. A not-acknowledge from the master ends the read.
- R8: The slave changes `sda_oe` only while SCL is low, and it releases SDA once a stop is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset that loads the defaults |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | NREG*8 | Committed registers, register i at bits 8*i+7 down to 8*i |

## Verification
A wrong byte index or a misrouted data byte shows up on `cfg_o` within about three system clocks of the acknowledge slot. The bench compares all 21 registers after each transaction, so such an error is caught at the next stop. A pair that commits early, or commits from a partial transaction, is visible the cycle after the stop or repeated start, and the repeated-start test also reads the pair back over the bus. A wrong read count or a shifted read index appears in the very next byte the master clocks in, and a misplaced drive edge breaks the acknowledge seen in the same bit slot.

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 21,
  parameter int         CNT_REG  = 8,
  parameter int         PAIR_A   = 11,
  parameter int         PAIR_B   = 13,
  parameter logic [7:0] CNT_DFLT = 8'h08,
  parameter logic [7:0] WDT_DFLT = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int         IW  = $clog2(NREG);
  localparam logic [7:0] NR8 = 8'(NREG);
  localparam logic [7:0] CR8 = 8'(CNT_REG);
  localparam logic [7:0] PA8 = 8'(PAIR_A);
  localparam logic [7:0] PB8 = 8'(PAIR_B);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, idle;
  logic [3:0] bitcnt;
  logic [7:0] shf, txb, bno, bno_nx, widx, tx_first, tx_next;
  logic       is_addr, rw, nack;
  logic [7:0] rf  [NREG];
  logic [7:0] shd [4];
  logic [3:0] got, pair_hit;

  function automatic logic [7:0] dflt(input int i);
    if (i == CNT_REG)     return CNT_DFLT;
    if (i == CNT_REG + 1) return WDT_DFLT;
    return 8'h00;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [7:0] k);
    if (k < rf[CNT_REG] && k < NR8) return rf[k[IW-1:0]];
    return 8'hFF;
  endfunction

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_s & ~scl_q[2];
  assign scl_fall  = ~scl_s & scl_q[2];
  assign start_det = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  assign stop_det  = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  assign idle      = (st == S_IDLE);
  assign bno_nx    = (bno == 8'hFF) ? bno : bno + 8'd1;
  assign widx      = bno - 8'd2;
  assign pair_hit  = {widx == PB8 + 8'd1, widx == PB8, widx == PA8 + 8'd1, widx == PA8};
  assign tx_first  = rd_byte(bno);
  assign tx_next   = rd_byte(bno_nx);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = rf[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sda_oe  <= 1'b0;
      bitcnt  <= '0;
      shf     <= '0;
      txb     <= '0;
      bno     <= '0;
      is_addr <= 1'b0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      got     <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= dflt(i);
      for (int j = 0; j < 4; j++) shd[j] <= '0;
    end else if (stop_det || start_det) begin
      if (got[0] && got[1]) begin
        rf[PAIR_A]     <= shd[0];
        rf[PAIR_A + 1] <= shd[1];
      end
      if (got[2] && got[3]) begin
        rf[PAIR_B]     <= shd[2];
        rf[PAIR_B + 1] <= shd[3];
      end
      got     <= '0;
      sda_oe  <= 1'b0;
      bitcnt  <= '0;
      bno     <= '0;
      rw      <= 1'b0;
      is_addr <= start_det;
      st      <= start_det ? S_RX : S_IDLE;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shf    <= {shf[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (is_addr) begin
              if (shf[7:1] == DEV_ADDR) begin
                st     <= S_RACK;
                sda_oe <= 1'b1;
                rw     <= shf[0];
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st     <= S_RACK;
              sda_oe <= 1'b1;
              bno    <= bno_nx;
              if (bno >= 8'd2 && widx < NR8) begin
                if (|pair_hit) begin
                  for (int j = 0; j < 4; j++)
                    if (pair_hit[j]) begin
                      shd[j] <= shf;
                      got[j] <= 1'b1;
                    end
                end else if (!(widx == CR8 && shf == 8'h00)) begin
                  rf[widx[IW-1:0]] <= shf;
                end
              end
            end
          end
        end
        S_RACK: begin
          if (scl_fall) begin
            is_addr <= 1'b0;
            bitcnt  <= '0;
            if (is_addr && rw) begin
              st     <= S_TX;
              txb    <= tx_first;
              sda_oe <= ~tx_first[7];
            end else begin
              st     <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st     <= S_TACK;
              sda_oe <= 1'b0;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              txb    <= txb << 1;
              sda_oe <= ~txb[6];
            end
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              st <= S_IDLE;
            end else begin
              st     <= S_TX;
              bno    <= bno_nx;
              bitcnt <= '0;
              txb    <= tx_next;
              sda_oe <= ~tx_next[7];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_cfg_bank_chk.sv
module smb_cfg_bank_chk #(
  parameter int NREG    = 21,
  parameter int CNT_REG = 8,
  parameter int PAIR_A  = 11,
  parameter int PAIR_B  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              idle,
  input logic [NREG*8-1:0] cfg_o
);
  p_cnt_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[CNT_REG*8 +: 8] != 8'h00);

  p_pair_a_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o[PAIR_A*8 +: 16]) |-> $past(stop_det || start_det));

  p_pair_b_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o[PAIR_B*8 +: 16]) |-> $past(stop_det || start_det));

  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_release_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
endmodule

bind smb_cfg_bank smb_cfg_bank_chk #(
  .NREG(NREG), .CNT_REG(CNT_REG), .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .idle(idle), .cfg_o(cfg_o)
);

// File: tb/sim_smb_cfg_bank.sv
`timescale 1ns/1ps
module sim_smb_cfg_bank;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int NR = 21;
  localparam int Q  = 5;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] cfg;
  wire  sda_line = sda_m & ~sda_oe;

  smb_cfg_bank u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                   .sda_oe(sda_oe), .cfg_o(cfg));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, viol = 0, g_acks = 0;
  bit done = 1'b0, g_addr_ack = 1'b0, oe_prev = 1'b0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic [7:0] g_cmd = 8'h00, g_cnt = 8'h00;

  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != oe_prev) viol++;
    oe_prev = sda_oe;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    int bad = -1;
    for (int i = NR - 1; i >= 0; i--) if (cfg[i*8 +: 8] !== mdl[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "registers", 0, 0);
    else chk(1'b0, req, $sformatf("register %0d", bad), int'(cfg[bad*8 +: 8]), int'(mdl[bad]));
  endtask

  function automatic void mdl_reset();
    for (int i = 0; i < NR; i++) mdl[i] = (i == 8) ? 8'h08 : (i == 9) ? 8'h10 : 8'h00;
  endfunction

  function automatic void mdl_apply(input int n);
    for (int k = 0; k < n && k < NR; k++) begin
      if (k >= 11 && k <= 14) continue;
      if (k == 8 && wbuf[k] == 8'h00) continue;
      mdl[k] = wbuf[k];
    end
    if (n >= 13) begin mdl[11] = wbuf[11]; mdl[12] = wbuf[12]; end
    if (n >= 15) begin mdl[13] = wbuf[13]; mdl[14] = wbuf[14]; end
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    return (k < int'(mdl[8]) && k < NR) ? mdl[k] : 8'hFF;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); ack = (sda_line == 1'b0); hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl = 1'b1; hold(Q); b[i] = sda_line; hold(Q); scl = 1'b0;
    end
    hold(2); sda_m = give_ack ? 1'b0 : 1'b1; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0;
    hold(2); sda_m = 1'b1; hold(Q);
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input bit keep_bus);
    bit ack;
    g_acks = 0;
    bus_start();
    put_byte({a, 1'b0}, ack); g_acks += int'(ack);
    put_byte(g_cmd, ack);     g_acks += int'(ack);
    put_byte(g_cnt, ack);     g_acks += int'(ack);
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], ack); g_acks += int'(ack);
    end
    if (!keep_bus) bus_stop();
    hold(4);
  endtask

  task automatic do_read(input logic [6:0] a, input int n);
    logic [7:0] b;
    bus_start();
    put_byte({a, 1'b1}, g_addr_ack);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, b);
      rbuf[k] = b;
    end
    bus_stop();
    hold(4);
  endtask

  task automatic check_read(input int n, input string req);
    for (int k = 0; k < n; k++)
      chk(rbuf[k] == exp_rd(k), req, $sformatf("read byte %0d", k), int'(rbuf[k]), int'(exp_rd(k)));
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(1, 255));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mdl_reset();
    hold(10);
    rst_n = 1'b1;
    hold(10);

    check_regs("R1");
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    g_cmd = 8'hAB; g_cnt = 8'h01;
    do_write(ADDR, 3, 1'b0);
    chk(g_acks == 6, "R2", "acks on matching write", g_acks, 6);
    mdl_apply(3);
    check_regs("R3");

    for (int k = 0; k < 5; k++) wbuf[k] = 8'hEE;
    do_write(7'h2A, 5, 1'b0);
    chk(g_acks == 0, "R2", "acks on foreign address", g_acks, 0);
    check_regs("R2");

    fill(12); do_write(ADDR, 12, 1'b0); mdl_apply(12);
    check_regs("R5");
    fill(13); do_write(ADDR, 13, 1'b0); mdl_apply(13);
    check_regs("R5");
    fill(14); do_write(ADDR, 14, 1'b0); mdl_apply(14);
    check_regs("R5");
    fill(15); do_write(ADDR, 15, 1'b0); mdl_apply(15);
    check_regs("R5");

    fill(9); wbuf[8] = 8'h00; do_write(ADDR, 9, 1'b0); mdl_apply(9);
    chk(cfg[8*8 +: 8] == mdl[8] && mdl[8] != 8'h00, "R6", "count kept after zero write",
        int'(cfg[8*8 +: 8]), int'(mdl[8]));

    fill(24); g_cnt = 8'h02; do_write(ADDR, 24, 1'b0); mdl_apply(24);
    chk(g_acks == 27, "R4", "acks on long write", g_acks, 27);
    check_regs("R4");

    fill(9); wbuf[8] = 8'h05; do_write(ADDR, 9, 1'b0); mdl_apply(9);
    do_read(ADDR, 8);
    chk(g_addr_ack, "R7", "read address ack", int'(g_addr_ack), 1);
    check_read(8, "R7");

    fill(9); wbuf[8] = 8'd21; do_write(ADDR, 9, 1'b0); mdl_apply(9);
    fill(12); wbuf[8] = 8'd21; do_write(ADDR, 12, 1'b1); mdl_apply(12);
    do_read(ADDR, 21);
    check_read(21, "R5");
    check_regs("R5");

    do_read(7'h15, 2);
    chk(!g_addr_ack, "R2", "read foreign address ack", int'(g_addr_ack), 0);

    for (int it = 0; it < 16; it++) begin
      int n = $urandom_range(0, 22);
      int m = $urandom_range(1, 12);
      fill(n);
      if ($urandom_range(0, 3) == 0) wbuf[8] = 8'h00;
      g_cmd = 8'($urandom()); g_cnt = 8'($urandom());
      do_write(ADDR, n, 1'b0);
      chk(g_acks == n + 3, "R4", "acks on random write", g_acks, n + 3);
      mdl_apply(n);
      check_regs("R4");
      do_read(ADDR, m);
      check_read(m, "R7");
    end

    chk(viol == 0, "R8", "sda_oe changes while SCL high", viol, 0);
    chk(sda_oe == 1'b0, "R8", "sda_oe after final stop", int'(sda_oe), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule